// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Flow Control

This block receives 8-bit words over a two-wire link made of a synchronization clock and a data line. The clock comes from the sender, so the receiver has no baud timing of its own. Both lines are brought into the system clock domain through two-flop synchronizers. A rising edge of the synchronized clock samples one data bit into a shift register. Bit 0 arrives first and bit 7 last, with no start, stop or parity bits. After the eighth bit the word is offered to a holding register that the CPU reads through a one-cycle read strobe.

If the holding register still has an unread word when a new word completes, the new word is dropped and a sticky overrun flag is set. Software clears that flag with a one-cycle clear strobe. Single-cycle request pulses report a stored word and a dropped word, and both are gated by the interrupt enable input. An active-low ready-to-send output lets the sender pace itself. It is low only while reception is enabled, the flow-control function is turned on and the holding register is empty. Dropping the receive enable abandons any partly received word.

Top module: `csync_rx`

## Requirements
- R1: After reset, `rdata` is 0, `ovf_flag` is 0, `rts_n` is 1, and neither request output pulses.
- R2: While `rx_en` is 1, each rising edge of `sck_in` samples `sdat_in`. The first bit sampled goes to `rdata` bit 0 and the eighth to bit 7. After the eighth edge the word appears on `rdata` if the holding register was empty and `ovf_flag` is 0.
- R3: Each stored word gives exactly one single-cycle pulse on `done_irq` when `rie` is 1, and none when `rie` is 0.
- R4: A word that completes while the holding register is unread is dropped. `rdata` keeps its old value and `ovf_flag` becomes 1.
- R5: Each dropped word gives one single-cycle pulse on `err_irq` when `rie` is 1, and none when `rie` is 0. It never gives a `done_irq` pulse.
- R6: While `ovf_flag` is 1, every completed word is dropped, even if `rdata` has been read. `ovf_flag` stays 1 until a one-cycle pulse on `ovf_clr` clears it.
- R7: With `rts_use` at 1 and `rx_en` at 1, `rts_n` is 0 while the holding register is empty. It goes to 1 when a word is stored and returns to 0 after the `rd_stb` pulse.
- R8: With `rts_use` at 0, `rts_n` stays 1.
- R9: With `rx_en` at 0, `rts_n` is 1 and the bit counter is cleared, so a partly received word is lost. The next word after re-enabling is received whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_in | input | 1 | Synchronization clock from the sender, idles high |
| sdat_in | input | 1 | Serial data, sampled on rising `sck_in` |
| rx_en | input | 1 | Receive enable |
| rie | input | 1 | Enable for both request pulses |
| rts_use | input | 1 | Enables the ready-to-send function |
| rd_stb | input | 1 | One-cycle pulse: CPU has read `rdata` |
| ovf_clr | input | 1 | One-cycle pulse: clear the overrun flag |
| rdata | output | 8 | Holding register contents |
| ovf_flag | output | 1 | Sticky overrun flag |
| done_irq | output | 1 | Word-stored request pulse |
| err_irq | output | 1 | Word-dropped request pulse |
| rts_n | output | 1 | Active-low ready-to-send |

## Verification
All 256 byte values are received in turn, each read before the next word arrives. This shows whether bits land in the right order and position, and whether the flow-control line rises on storage and falls on the read. A word sent into an unread register, and then another word sent after the read but before the flag is cleared, separate the overrun case from the sticky-discard case. A word sent with the interrupt enable off shows that the enable gates the request pulses. Three bits followed by a disable and then a full word show whether the bit counter restarts.

// File: rtl/csync_rx_pkg.sv
package csync_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  // LSB-first shift: the newest bit enters at the top, so the first bit
  // ends at position 0 after DATA_W shifts.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] word,
                                                 input logic bit_in);
    return {bit_in, word[DATA_W-1:1]};
  endfunction

  function automatic logic last_bit(input logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(DATA_W - 1);
  endfunction
endpackage

// File: rtl/csync_rx_sync.sv
module csync_rx_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_SCK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdat_in,
  output logic sck_rise,
  output logic sdat_s
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= {STAGES{IDLE_SCK}};
      dat_pipe <= '0;
      sck_prev <= IDLE_SCK;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
      dat_pipe <= {dat_pipe[STAGES-2:0], sdat_in};
      sck_prev <= sck_pipe[STAGES-1];
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_prev;
  assign sdat_s   = dat_pipe[STAGES-1];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise); // R2
endmodule

// File: rtl/csync_rx_shift.sv
module csync_rx_shift
  import csync_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              sck_rise,
  input  logic              sdat_s,
  output logic              frame_v,
  output logic [DATA_W-1:0] frame_word
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic              take_bit;

  assign take_bit = rx_en & sck_rise;
  assign sh_next  = shift_in(sh_q, sdat_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      frame_v    <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_v <= 1'b0;
      if (!rx_en) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (take_bit) begin
        sh_q  <= sh_next;
        cnt_q <= last_bit(cnt_q) ? '0 : cnt_q + 1'b1;
        if (last_bit(cnt_q)) begin
          frame_v    <= 1'b1;
          frame_word <= sh_next;
        end
      end
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (cnt_q == '0) && !frame_v); // R9
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_v |=> !frame_v); // R3
endmodule

// File: rtl/csync_rx_ctrl.sv
module csync_rx_ctrl
  import csync_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rie,
  input  logic              rts_use,
  input  logic              rd_stb,
  input  logic              ovf_clr,
  input  logic              frame_v,
  input  logic [DATA_W-1:0] frame_word,
  output logic [DATA_W-1:0] rdata,
  output logic              ovf_flag,
  output logic              done_irq,
  output logic              err_irq,
  output logic              rts_n
);
  logic full_q;
  logic full_d;
  logic ovf_d;
  logic store_w;
  logic drop_w;

  assign store_w = frame_v & ~full_q & ~ovf_flag;
  assign drop_w  = frame_v & (full_q | ovf_flag);

  always_comb begin
    full_d = full_q;
    if (store_w)     full_d = 1'b1;
    else if (rd_stb) full_d = 1'b0;
    ovf_d = ovf_flag;
    if (drop_w)       ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      full_q   <= 1'b0;
      ovf_flag <= 1'b0;
      done_irq <= 1'b0;
      err_irq  <= 1'b0;
      rts_n    <= 1'b1;
    end else begin
      if (store_w) rdata <= frame_word;
      full_q   <= full_d;
      ovf_flag <= ovf_d;
      done_irq <= store_w & rie;
      err_irq  <= drop_w & rie;
      rts_n    <= ~(rx_en & rts_use & ~full_d);
    end
  end

  AST_DROP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> $stable(rdata)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R6
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_irq && err_irq)); // R5
  AST_ERR_NEEDS_RIE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w && !rie |=> !err_irq); // R5
  AST_RTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && rts_use) |=> rts_n); // R8
endmodule

// File: rtl/csync_rx.sv
module csync_rx
  import csync_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_in,
  input  logic              sdat_in,
  input  logic              rx_en,
  input  logic              rie,
  input  logic              rts_use,
  input  logic              rd_stb,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              ovf_flag,
  output logic              done_irq,
  output logic              err_irq,
  output logic              rts_n
);
  logic              rise_w;
  logic              bit_w;
  logic              frame_v_w;
  logic [DATA_W-1:0] frame_word_w;

  csync_rx_sync #(.STAGES(2), .IDLE_SCK(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdat_in(sdat_in),
    .sck_rise(rise_w), .sdat_s(bit_w)
  );

  csync_rx_shift i_shift (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sck_rise(rise_w),
    .sdat_s(bit_w), .frame_v(frame_v_w), .frame_word(frame_word_w)
  );

  csync_rx_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rie(rie), .rts_use(rts_use),
    .rd_stb(rd_stb), .ovf_clr(ovf_clr), .frame_v(frame_v_w),
    .frame_word(frame_word_w), .rdata(rdata), .ovf_flag(ovf_flag),
    .done_irq(done_irq), .err_irq(err_irq), .rts_n(rts_n)
  );

  AST_DONE_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(frame_v_w)); // R3
  AST_RTS_HIGH_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> rts_n); // R7
endmodule

// File: tb/test_csync_rx.sv
module test_csync_rx;
  localparam int CLK_HALF = 5;
  localparam int HALF_BIT = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck_in = 1'b1;
  logic sdat_in = 1'b0;
  logic rx_en = 1'b0;
  logic rie = 1'b0;
  logic rts_use = 1'b0;
  logic rd_stb = 1'b0;
  logic ovf_clr = 1'b0;
  logic [7:0] rdata;
  logic ovf_flag, done_irq, err_irq, rts_n;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  bit finished = 1'b0;

  always #CLK_HALF clk = ~clk;

  csync_rx i_csync_rx (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdat_in(sdat_in),
    .rx_en(rx_en), .rie(rie), .rts_use(rts_use), .rd_stb(rd_stb),
    .ovf_clr(ovf_clr), .rdata(rdata), .ovf_flag(ovf_flag),
    .done_irq(done_irq), .err_irq(err_irq), .rts_n(rts_n)
  );

  always @(negedge clk) begin
    if (done_irq) done_cnt++;
    if (err_irq) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits of value, bit 0 first; clock falls with new data, rises mid-bit.
  task automatic send_bits(input logic [7:0] value, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdat_in = value[i];
      sck_in = 1'b0;
      wait_clk(HALF_BIT);
      sck_in = 1'b1;
      wait_clk(HALF_BIT);
    end
    wait_clk(4);
  endtask

  task automatic pulse_rd();
    rd_stb = 1'b1;
    wait_clk(1);
    rd_stb = 1'b0;
    wait_clk(1);
  endtask

  initial begin
    int d0, e0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    chk(ovf_flag == 1'b0, "R1 ovf_flag", ovf_flag, 0);
    chk(rts_n == 1'b1, "R1 rts_n", rts_n, 1);
    chk(done_cnt == 0 && err_cnt == 0, "R1 irq", done_cnt + err_cnt, 0);

    rts_use = 1'b1;
    rie = 1'b1;
    rx_en = 1'b1;
    wait_clk(2);
    chk(rts_n == 1'b0, "R7 rts low on enable", rts_n, 0);

    // R2/R3/R7 full sweep of byte values, LSB first
    for (int v = 0; v < 256; v++) begin
      d0 = done_cnt;
      send_bits(8'(v), 8);
      chk(rdata == 8'(v), "R2 word", rdata, v);
      chk(done_cnt == d0 + 1, "R3 one pulse", done_cnt, d0 + 1);
      chk(rts_n == 1'b1, "R7 rts high after store", rts_n, 1);
      pulse_rd();
      chk(rts_n == 1'b0, "R7 rts low after read", rts_n, 0);
    end

    // R3 rie off suppresses pulse
    rie = 1'b0;
    d0 = done_cnt;
    send_bits(8'h3C, 8);
    chk(rdata == 8'h3C, "R2 word rie=0", rdata, 'h3C);
    chk(done_cnt == d0, "R3 no pulse rie=0", done_cnt, d0);
    pulse_rd();
    rie = 1'b1;

    // R4/R5 overrun
    send_bits(8'hA5, 8);
    d0 = done_cnt;
    e0 = err_cnt;
    send_bits(8'h5A, 8);
    chk(rdata == 8'hA5, "R4 rdata kept", rdata, 'hA5);
    chk(ovf_flag == 1'b1, "R4 ovf set", ovf_flag, 1);
    chk(err_cnt == e0 + 1, "R5 err pulse", err_cnt, e0 + 1);
    chk(done_cnt == d0, "R5 no done on drop", done_cnt, d0);

    // R6 sticky discard after read
    pulse_rd();
    d0 = done_cnt;
    send_bits(8'hC3, 8);
    chk(rdata == 8'hA5, "R6 discard while ovf", rdata, 'hA5);
    chk(done_cnt == d0, "R6 no done while ovf", done_cnt, d0);
    chk(ovf_flag == 1'b1, "R6 ovf stays", ovf_flag, 1);
    ovf_clr = 1'b1;
    wait_clk(1);
    ovf_clr = 1'b0;
    wait_clk(1);
    chk(ovf_flag == 1'b0, "R6 ovf cleared", ovf_flag, 0);
    send_bits(8'h96, 8);
    chk(rdata == 8'h96, "R6 receive after clear", rdata, 'h96);

    // R5 rie off: drop without err pulse
    rie = 1'b0;
    e0 = err_cnt;
    send_bits(8'h11, 8);
    chk(ovf_flag == 1'b1, "R5 ovf rie=0", ovf_flag, 1);
    chk(err_cnt == e0, "R5 no err rie=0", err_cnt, e0);
    pulse_rd();
    ovf_clr = 1'b1;
    wait_clk(1);
    ovf_clr = 1'b0;
    rie = 1'b1;

    // R8 flow control off
    rts_use = 1'b0;
    wait_clk(2);
    chk(rts_n == 1'b1, "R8 rts idle", rts_n, 1);
    send_bits(8'h7E, 8);
    chk(rdata == 8'h7E, "R8 word", rdata, 'h7E);
    pulse_rd();
    chk(rts_n == 1'b1, "R8 rts after read", rts_n, 1);
    rts_use = 1'b1;

    // R9 abort partial word
    send_bits(8'hFF, 3);
    rx_en = 1'b0;
    wait_clk(2);
    chk(rts_n == 1'b1, "R9 rts high when off", rts_n, 1);
    chk(rdata == 8'h7E, "R9 partial not stored", rdata, 'h7E);
    rx_en = 1'b1;
    wait_clk(2);
    d0 = done_cnt;
    send_bits(8'h4B, 8);
    chk(rdata == 8'h4B, "R9 whole word after re-enable", rdata, 'h4B);
    chk(done_cnt == d0 + 1, "R9 one pulse", done_cnt, d0 + 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(negedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule